// File: doc/BRIEF.md
# System Controller Register Bank

This block is a small memory-mapped register bank for platform control. It sits on a simple 32-bit bus that addresses whole words: the bus carries a word index, which is the byte offset divided by four. The window covers 1024 words (4 KiB). Only the lower 512 words have storage behind them. A master raises `req` and the access is taken on any clock edge where `ready` is also high. Writes always carry a full 32-bit word. The data for a read appears on `rdata`, with `rvalid` high, one cycle after the access is taken.

Four words at word indices 0x40 to 0x43 hold identification values that are loaded at reset. Three of them, at indices 0x40, 0x42 and 0x43, read back with bits 29:28 forced to one. The stored value does not change.

Word index 0x3C0 (byte offset 0xF00) is a command slot. It lies above the backed storage. A write there asks the platform either to reset or to shut down, and the choice depends on the data written. Any access above the backed storage, the command slot included, raises a one-cycle error pulse.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, reads return these values. Index 0x40 gives 0x35F20121, index 0x41 gives 0x00000002, index 0x42 gives 0x35F30121 and index 0x43 gives 0x35F40121. The stored values are 0x05F20121, 0x00000002, 0x05F30121 and 0x05F40121.
- R2: Every other backed word (index 0x000 to 0x1FF) reads zero after reset.
- R3: A read of an ordinary backed word returns the last value written to it. `rvalid` is high for exactly one cycle, the cycle after the read is taken. Nothing happens unless `req` and `ready` are both high.
- R4: Reads at word indices 0x40, 0x42 and 0x43 return the stored word ORed with 0x30000000. The stored word keeps its value, and a read of index 0x41 shows no forced bits.
- R5: A write to index 0x3C0 with data 1 or data 2 pulses `reset_req` high for one cycle, in the cycle after the write is taken.
- R6: A write to index 0x3C0 with data 3 pulses `shutdown_req` high for one cycle, in the cycle after the write is taken.
- R7: A write to index 0x3C0 with any other data raises neither `reset_req` nor `shutdown_req`.
- R8: For an access at index 0x200 or above, a write stores nothing (it does not alias onto the lower words) and a read returns zero. Both raise `access_err` for one cycle, in the cycle after the access.
- R9: A command write also raises `access_err` and stores nothing.
- R10: `ready` is low while reset is asserted and high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Word index (byte offset / 4) |
| wdata | input | 32 | Write data |
| ready | output | 1 | Bank can take a request |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | `rdata` is valid (one cycle) |
| reset_req | output | 1 | Platform reset request pulse |
| shutdown_req | output | 1 | Platform shutdown request pulse |
| access_err | output | 1 | Out-of-range access pulse |

## Verification
Every register in this bank drives a port in the cycle right after an access, so a wrong state inside it shows up quickly.

- A corrupted word, such as a bad reset value, a write that went to the wrong index, or an out-of-range write that wrapped onto low storage, shows on `rdata` in the cycle after the next read of that word.
- A wrong decode of the command slot or of the range limit shows in the very next cycle, as a missing or extra pulse on `reset_req`, `shutdown_req` or `access_err`.

The bench keeps its own model of the word array, updated every clock. It compares all outputs against that model on every cycle, so a fault surfaces at the first access that touches it.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int          IDX_W     = 10,
  parameter int          DATA_W    = 32,
  parameter int          WORDS     = 512,
  parameter int          CMD_IDX   = 'h3C0,
  parameter int          ID_IDX    = 'h40,
  parameter logic [31:0] FORCE_SET = 32'h3000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              reset_req,
  output logic              shutdown_req,
  output logic              access_err
);
  localparam int SW = $clog2(WORDS);

  logic [DATA_W-1:0] mem [WORDS];

  wire          take     = req && ready;
  wire          in_range = {1'b0, addr} < (IDX_W+1)'(WORDS);
  wire [SW-1:0] sidx     = addr[SW-1:0];
  wire          is_cmd   = addr == IDX_W'(CMD_IDX);
  wire          forced   = addr == IDX_W'(ID_IDX) || addr == IDX_W'(ID_IDX + 2) ||
                           addr == IDX_W'(ID_IDX + 3);
  wire [DATA_W-1:0] ovl  = forced ? DATA_W'(FORCE_SET) : '0;

  function automatic logic [DATA_W-1:0] init_word(input int i);
    case (i - ID_IDX)
      0:       return DATA_W'(32'h05F2_0121);
      1:       return DATA_W'(32'h0000_0002);
      2:       return DATA_W'(32'h05F3_0121);
      3:       return DATA_W'(32'h05F4_0121);
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= init_word(i);
    end else if (take && we && in_range) begin
      mem[sidx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready        <= 1'b0;
      rdata        <= '0;
      rvalid       <= 1'b0;
      reset_req    <= 1'b0;
      shutdown_req <= 1'b0;
      access_err   <= 1'b0;
    end else begin
      ready        <= 1'b1;
      rvalid       <= take && !we;
      access_err   <= take && !in_range;
      reset_req    <= take && we && is_cmd && (wdata == 1 || wdata == 2);
      shutdown_req <= take && we && is_cmd && wdata == 3;
      if (take && !we) rdata <= in_range ? (mem[sidx] | ovl) : '0;
    end
  end
endmodule

module sysctl_regs_chk #(
  parameter int IDX_W   = 10,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 512,
  parameter int CMD_IDX = 'h3C0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [IDX_W-1:0]  addr,
  input logic [DATA_W-1:0] wdata,
  input logic              ready,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic              reset_req,
  input logic              shutdown_req,
  input logic              access_err
);
  wire oor = {1'b0, addr} >= (IDX_W+1)'(WORDS);

  assert_rvalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(req && ready && !we));
  assert_reset_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(req && ready && we && addr == IDX_W'(CMD_IDX) &&
                        (wdata == 1 || wdata == 2)));
  assert_shutdown_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(req && ready && we && addr == IDX_W'(CMD_IDX) && wdata == 3));
  assert_one_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reset_req, shutdown_req}));
  assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> $past(req && ready && oor));
  assert_oor_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && !we && oor) |=> (rvalid && rdata == '0));
  assert_cmd_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || shutdown_req) |-> access_err);
endmodule

bind sysctl_regs sysctl_regs_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .WORDS(WORDS), .CMD_IDX(CMD_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .ready(ready), .rdata(rdata), .rvalid(rvalid), .reset_req(reset_req),
  .shutdown_req(shutdown_req), .access_err(access_err)
);

// File: tb/test_sysctl_regs.sv
module test_sysctl_regs;
  logic        clk = 0, rst_n = 0, req = 0, we = 0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ready, rvalid, reset_req, shutdown_req, access_err;
  logic [31:0] rdata;

  always #10 clk = ~clk;

  sysctl_regs i_sysctl_regs (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .reset_req(reset_req),
    .shutdown_req(shutdown_req), .access_err(access_err)
  );

  logic [31:0] m [512];
  bit          touched [512];
  logic        e_ready, e_rv, e_rst, e_shut, e_err, started;
  logic [31:0] e_rd;
  string       rtag, ctag;
  int          checks = 0, fails = 0, cycles = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) begin m[i] = 0; touched[i] = 0; end
      m['h40] = 32'h05F20121; m['h41] = 32'h2;
      m['h42] = 32'h05F30121; m['h43] = 32'h05F40121;
      e_ready = 0; e_rv = 0; e_rst = 0; e_shut = 0; e_err = 0; e_rd = 0;
      started = 0; rtag = "R3"; ctag = "R5";
    end else begin
      automatic bit take = req && e_ready;
      automatic int a = int'(addr);
      started = 1;
      e_rv = take && !we;
      e_err = take && a >= 512;
      e_rst = take && we && a == 'h3C0 && (wdata == 1 || wdata == 2);
      e_shut = take && we && a == 'h3C0 && wdata == 3;
      ctag = (take && we && a == 'h3C0) ? ((wdata >= 1 && wdata <= 3) ? "R5 R6" : "R7") : "R9";
      if (take && !we) begin
        if (a >= 512) begin e_rd = 0; rtag = "R8"; end
        else begin
          e_rd = m[a];
          if (a == 'h40 || a == 'h42 || a == 'h43) begin e_rd = e_rd | 32'h30000000; rtag = "R4"; end
          else rtag = touched[a] ? "R3" : (a >= 'h40 && a <= 'h43 ? "R1" : "R2");
          if (!touched[a] && a >= 'h40 && a <= 'h43) rtag = "R1";
        end
      end
      if (take && we && a < 512) begin m[a] = wdata; touched[a] = 1; end
      e_ready = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(ready == e_ready, "R10", 32'(ready), 32'(e_ready));
    chk(rvalid == e_rv, "R3", 32'(rvalid), 32'(e_rv));
    chk(reset_req == e_rst, ctag == "R7" ? "R7" : "R5", 32'(reset_req), 32'(e_rst));
    chk(shutdown_req == e_shut, ctag == "R7" ? "R7" : "R6", 32'(shutdown_req), 32'(e_shut));
    chk(access_err == e_err, "R8 R9", 32'(access_err), 32'(e_err));
    if (e_rv) chk(rdata == e_rd, rtag, rdata, e_rd);
  end

  task automatic acc(input bit w, input int a, input logic [31:0] d);
    @(negedge clk); req = 1; we = w; addr = 10'(a); wdata = d;
    @(negedge clk); req = 0;
  endtask

  task automatic rd(input int a); acc(0, a, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R2: reset contents
    rd('h40); rd('h41); rd('h42); rd('h43); rd('h000); rd('h1FF); rd('h44);
    // R3: plain storage, back-to-back
    acc(1, 'h005, 32'hDEADBEEF); acc(1, 'h1FF, 32'h12345678); rd('h005); rd('h1FF);
    // R4: overlay does not alter storage
    acc(1, 'h40, 32'h0); rd('h40); acc(1, 'h42, 32'hCFFFFFFF); rd('h42);
    acc(1, 'h41, 32'h0000_0001); rd('h41); acc(1, 'h43, 32'h3000_0000); rd('h43);
    // R5 R6 R7 R9: command slot
    acc(1, 'h3C0, 0); acc(1, 'h3C0, 1); acc(1, 'h3C0, 2); acc(1, 'h3C0, 3);
    acc(1, 'h3C0, 4); acc(1, 'h3C0, 32'h0000_0101); rd('h3C0); rd('h1C0);
    // R8: out of range, no aliasing onto low words
    acc(1, 'h200, 32'hAAAA5555); acc(1, 'h205, 32'h1111); rd('h000); rd('h005);
    rd('h200); rd('h3FF); acc(1, 'h3FF, 32'hFFFFFFFF); rd('h1FF);
    // R3: requests ignored while req low
    @(negedge clk); we = 1; addr = 10'h005; wdata = 32'h0BAD0BAD;
    repeat (2) @(negedge clk); rd('h005);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule